// File: doc/BRIEF.md
# Software Reset Power-Down Sequencer

This block carries out the delayed shutdown that follows a software reset request. Software writes a two-bit command; a cold-reset or an off command in the idle state starts a fixed, tick-timed flow. The flow waits an initial delay, drops the active-low system reset output, waits a reset-hold interval, then turns off the regulator enable groups one slot at a time from the highest slot to the lowest, and finally waits out an output discharge period. At the end of the discharge it emits a one-cycle pulse that clears the register bank.

What follows depends on the command. A cold reset brings the slots back up from the lowest to the highest at slot intervals and then releases the system reset. An off command leaves every enable low and the reset asserted until a wake input arrives, which starts the same power-up. Two sticky cause flags record which command was accepted. A read strobe clears them. Only the power-on reset input clears them otherwise, so they survive the register-bank pulse. A single-cycle tick input sets the time base. The `TICK_10US` parameter gives the tick period in units of 10 us, so a bench can shorten every phase.

Top module: `swrst_sequencer`

## Requirements
- R1: When `cmd_valid` is high in the idle state, `cmd` = 2'b01 starts a cold-reset flow and `cmd` = 2'b10 starts an off flow. The values 2'b00 and 2'b11 leave the outputs and flags unchanged.
- R2: Phase lengths are counted in cycles with `tick` high, each at least 1: initial delay floor(6000/TICK_10US), reset hold floor(1024/TICK_10US), slot interval S = floor(256/TICK_10US), discharge floor(12500/TICK_10US). The flow does not advance on cycles without a tick.
- R3: `sys_rst_n` goes low once the initial delay ends and stays low until the power-up finishes. It is low whenever any slot enable is low.
- R4: After the reset hold, `slot_en[3]` drops first and then `slot_en[2]`, `slot_en[1]` and `slot_en[0]` follow one slot interval apart. The discharge starts one interval after `slot_en[0]` drops.
- R5: `regs_rst` is high for exactly one cycle, the cycle after the tick that ends the discharge.
- R6: In a cold reset, `slot_en[0]` rises on the tick that ends the discharge, `slot_en[1..3]` follow one interval apart, and `sys_rst_n` rises one interval after `slot_en[3]`. The block then returns to idle.
- R7: After an off flow, all enables stay low and `sys_rst_n` stays low until `wake` is high. That cycle starts the R6 power-up. `wake` has no effect in any other state.
- R8: Any command arriving while a flow runs or while the block is off is ignored.
- R9: `cold_flag` or `off_flag` is set on the cycle its command is accepted. A `flag_rd` cycle clears both flags, but a set in that same cycle wins. The flags keep their value through `regs_rst`.
- R10: While reset, all slot enables are high, `sys_rst_n` is high, `regs_rst` is low and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Time-base pulse, one per tick period |
| cmd_valid | input | 1 | Command write strobe |
| cmd | input | 2 | Software reset command |
| wake | input | 1 | Wake event while off |
| flag_rd | input | 1 | Cause flag read strobe (clears flags) |
| slot_en | output | 4 | Regulator enable per power-down slot |
| sys_rst_n | output | 1 | Active-low system reset output |
| regs_rst | output | 1 | One-cycle register-bank reset pulse |
| cold_flag | output | 1 | Sticky cold-reset cause |
| off_flag | output | 1 | Sticky off cause |

## Verification
The hardest case to reach from the ports is a phase boundary where `tick` is irregular and a command, a wake or a flag read lands on the same cycle. The bench keeps its own count of accepted ticks and compares every output on every cycle against timing computed from that count. Tick density varies from run to run, and commands, wake pulses and flag reads are injected at random throughout each flow. An off flow is started together with a read strobe to exercise set-over-clear priority. A power-on reset is applied mid-flow.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DELAY  = 3'd1,
    PH_HOLD   = 3'd2,
    PH_SLOTDN = 3'd3,
    PH_DISCH  = 3'd4,
    PH_OFF    = 3'd5,
    PH_SLOTUP = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_COLD = 2'b01,
    CMD_OFF  = 2'b10,
    CMD_RSVD = 2'b11
  } cmd_e;

  // Ticks for a duration given in 10 us units, never below one.
  function automatic int unsigned phase_ticks(input int unsigned dur_10us,
                                              input int unsigned tick_10us);
    int unsigned t;
    t = dur_10us / tick_10us;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swrst_phase_timer.sv
module swrst_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign last   = run && tick && (cnt_q == limit - CW'(1));
  assign cnt_en = restart || (run && tick);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)          cnt_d = '0;
    else if (run && tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the tick count inside a phase never reaches its limit
  assert_cnt_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

  // R2: without a tick the count does not move
  assert_cnt_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/swrst_slot_bank.sv
module swrst_slot_bank #(
  parameter int N_SLOTS = 4,
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_en,
  input  logic               set_en,
  input  logic [IW-1:0]      idx,
  output logic [N_SLOTS-1:0] en
);

  logic [N_SLOTS-1:0] en_q;
  logic [N_SLOTS-1:0] en_d;
  logic               upd;

  assign upd = clr_en || set_en;

  always_comb begin
    en_d = en_q;
    if (clr_en) en_d[idx] = 1'b0;
    if (set_en) en_d[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '1;
    else if (upd) en_q <= en_d;
  end

  assign en = en_q;

  // R4 / R6: slots change one at a time
  assert_one_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q ^ $past(en_q)) <= 1);

endmodule

// File: rtl/swrst_cause_flags.sv
module swrst_cause_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cold,
  input  logic set_off,
  input  logic rd,
  output logic cold_flag,
  output logic off_flag
);

  logic cold_q, off_q;
  logic cold_d, off_d;
  logic upd;

  assign upd = set_cold || set_off || rd;

  always_comb begin
    cold_d = set_cold ? 1'b1 : (rd ? 1'b0 : cold_q);
    off_d  = set_off  ? 1'b1 : (rd ? 1'b0 : off_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cold_q <= 1'b0;
      off_q  <= 1'b0;
    end else if (upd) begin
      cold_q <= cold_d;
      off_q  <= off_d;
    end
  end

  assign cold_flag = cold_q;
  assign off_flag  = off_q;

  // R9: a flag only rises when its command was accepted
  assert_cold_rises_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_q && !$past(cold_q)) |-> $past(set_cold));
  assert_off_rises_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !$past(off_q)) |-> $past(set_off));

  // R9: a read without a set leaves both flags clear
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !set_cold && !set_off) |=> (!cold_q && !off_q));

endmodule

// File: rtl/swrst_sequencer.sv
module swrst_sequencer #(
  parameter int N_SLOTS   = 4,
  parameter int TICK_10US = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd,
  input  logic               wake,
  input  logic               flag_rd,
  output logic [N_SLOTS-1:0] slot_en,
  output logic               sys_rst_n,
  output logic               regs_rst,
  output logic               cold_flag,
  output logic               off_flag
);
  import swrst_pkg::*;

  localparam int unsigned LIM_DELAY = phase_ticks(6000,  TICK_10US);
  localparam int unsigned LIM_HOLD  = phase_ticks(1024,  TICK_10US);
  localparam int unsigned LIM_SLOT  = phase_ticks(256,   TICK_10US);
  localparam int unsigned LIM_DISCH = phase_ticks(12500, TICK_10US);
  localparam int unsigned LIM_MAX   =
    max2(max2(LIM_DELAY, LIM_HOLD), max2(LIM_SLOT, LIM_DISCH));
  localparam int CW = $clog2(LIM_MAX + 1);
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(N_SLOTS - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  phase_e        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          mode_cold_q, mode_cold_d;
  logic          pulse_q, pulse_d;
  logic          start, last, run;
  logic          slot_clr, slot_set;
  logic          set_cold, set_off;
  logic [CW-1:0] limit;
  logic          accept;

  assign accept = cmd_valid && ((cmd == CMD_COLD) || (cmd == CMD_OFF));
  assign run    = (phase_q != PH_IDLE) && (phase_q != PH_OFF);

  always_comb begin
    unique case (phase_q)
      PH_DELAY:             limit = CW'(LIM_DELAY);
      PH_HOLD:              limit = CW'(LIM_HOLD);
      PH_SLOTDN, PH_SLOTUP: limit = CW'(LIM_SLOT);
      PH_DISCH:             limit = CW'(LIM_DISCH);
      default:              limit = CW'(1);
    endcase
  end

  // next-state logic
  always_comb begin
    phase_d     = phase_q;
    idx_d       = idx_q;
    mode_cold_d = mode_cold_q;
    pulse_d     = 1'b0;
    start       = 1'b0;
    slot_clr    = 1'b0;
    slot_set    = 1'b0;
    set_cold    = 1'b0;
    set_off     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d     = PH_DELAY;
          mode_cold_d = (cmd == CMD_COLD);
          set_cold    = (cmd == CMD_COLD);
          set_off     = (cmd == CMD_OFF);
          start       = 1'b1;
        end
      end
      PH_DELAY: begin
        if (last) phase_d = PH_HOLD;
      end
      PH_HOLD: begin
        if (last) begin
          phase_d  = PH_SLOTDN;
          idx_d    = TOP_IDX;
          slot_clr = 1'b1;
        end
      end
      PH_SLOTDN: begin
        if (last) begin
          if (idx_q == '0) begin
            phase_d = PH_DISCH;
          end else begin
            idx_d    = idx_q - IW'(1);
            slot_clr = 1'b1;
          end
        end
      end
      PH_DISCH: begin
        if (last) begin
          pulse_d = 1'b1;
          idx_d   = '0;
          if (mode_cold_q) begin
            phase_d  = PH_SLOTUP;
            slot_set = 1'b1;
          end else begin
            phase_d = PH_OFF;
          end
        end
      end
      PH_OFF: begin
        if (wake) begin
          phase_d  = PH_SLOTUP;
          idx_d    = '0;
          slot_set = 1'b1;
          start    = 1'b1;
        end
      end
      PH_SLOTUP: begin
        if (last) begin
          if (idx_q == TOP_IDX) begin
            phase_d = PH_IDLE;
          end else begin
            idx_d    = idx_q + IW'(1);
            slot_set = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      phase_q     <= PH_IDLE;
      idx_q       <= '0;
      mode_cold_q <= 1'b0;
      pulse_q     <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      idx_q       <= idx_d;
      mode_cold_q <= mode_cold_d;
      pulse_q     <= pulse_d;
    end
  end

  swrst_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ok_q),
    .run     (run),
    .restart (start || last),
    .tick    (tick),
    .limit   (limit),
    .last    (last)
  );

  swrst_slot_bank #(.N_SLOTS(N_SLOTS)) u_slots (
    .clk    (clk),
    .rst_n  (rst_ok_q),
    .clr_en (slot_clr),
    .set_en (slot_set),
    .idx    (idx_d),
    .en     (slot_en)
  );

  swrst_cause_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_ok_q),
    .set_cold  (set_cold),
    .set_off   (set_off),
    .rd        (flag_rd),
    .cold_flag (cold_flag),
    .off_flag  (off_flag)
  );

  assign sys_rst_n = (phase_q == PH_IDLE) || (phase_q == PH_DELAY);
  assign regs_rst  = pulse_q;

  // R1: no-action and reserved codes leave the block idle
  assert_nop_cmd_idle_R1: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (phase_q == PH_IDLE && (!cmd_valid || cmd == CMD_NONE || cmd == CMD_RSVD))
      |=> (phase_q == PH_IDLE));

  // R3: reset output is low while any slot is off
  assert_rst_low_slot_off_R3: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (slot_en != '1) |-> !sys_rst_n);

  // R5: register-bank pulse lasts one cycle and follows the discharge
  assert_regrst_single_R5: assert property (@(posedge clk) disable iff (!rst_ok_q)
    regs_rst |=> !regs_rst);
  assert_regrst_after_disch_R5: assert property (@(posedge clk) disable iff (!rst_ok_q)
    regs_rst |-> ($past(phase_q) == PH_DISCH && !sys_rst_n));

  // R7: the off state is left only through wake
  assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (phase_q == PH_OFF && !wake) |=> (phase_q == PH_OFF));

  // R8: a flow starts only from idle
  assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (phase_q == PH_DELAY && $past(phase_q) != PH_DELAY) |-> ($past(phase_q) == PH_IDLE));

endmodule

// File: tb/swrst_sequencer_tb.sv
module swrst_sequencer_tb_top;

  localparam int TK  = 128;
  localparam int NS  = 4;

  function automatic int ticks_of(input int d);
    int t;
    t = d / TK;
    return (t == 0) ? 1 : t;
  endfunction

  localparam int TD = ticks_of(6000);
  localparam int TR = ticks_of(1024);
  localparam int TS = ticks_of(256);
  localparam int TX = ticks_of(12500);
  localparam int T1 = TD;
  localparam int T2 = TD + TR;
  localparam int T3 = T2 + NS * TS;
  localparam int T4 = T3 + TX;
  localparam int T5 = T4 + NS * TS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic wake = 1'b0;
  logic flag_rd = 1'b0;
  logic [NS-1:0] slot_en;
  logic sys_rst_n, regs_rst, cold_flag, off_flag;

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit ticked = 0;
  bit exp_cold = 0;
  bit exp_off = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swrst_sequencer #(.N_SLOTS(NS), .TICK_10US(TK)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd(cmd),
    .wake(wake), .flag_rd(flag_rd), .slot_en(slot_en), .sys_rst_n(sys_rst_n),
    .regs_rst(regs_rst), .cold_flag(cold_flag), .off_flag(off_flag)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (n=%0d)", tag, what, act, exp, n);
    end
  endtask

  function automatic logic [NS-1:0] exp_slots(input int cnt, input bit up);
    logic [NS-1:0] e;
    for (int k = 0; k < NS; k++)
      e[k] = (cnt < T2 + (NS - 1 - k) * TS) || (up && cnt >= T4 + k * TS);
    return e;
  endfunction

  function automatic bit exp_rst(input int cnt, input bit up);
    return (cnt < T1) || (up && cnt >= T5);
  endfunction

  task automatic check_outputs(input bit up);
    logic [NS-1:0] es;
    es = exp_slots(n, up);
    chk(slot_en == es, (n < T4) ? "R4" : (up ? "R6" : "R7"), "slot_en",
        int'(slot_en), int'(es));
    chk(sys_rst_n == exp_rst(n, up), "R3", "sys_rst_n", int'(sys_rst_n),
        int'(exp_rst(n, up)));
    chk(regs_rst == (n == T4 && ticked), "R5", "regs_rst", int'(regs_rst),
        int'(n == T4 && ticked));
    chk({cold_flag, off_flag} == {exp_cold, exp_off}, "R9", "flags",
        int'({cold_flag, off_flag}), int'({exp_cold, exp_off}));
  endtask

  // at a negedge on entry and exit
  task automatic run_loop(input bit up, input int stop_n, input int extra,
                          input int density, input bit inject, input bit rd_on);
    int post = 0;
    while (post < extra) begin
      check_outputs(up);
      tick = ($urandom_range(99) < density);
      if (inject && (!up || n < T5)) begin
        cmd_valid = $urandom_range(1);
        cmd = 2'($urandom_range(3));
        wake = up ? 1'($urandom_range(1)) : 1'b0;
      end else begin
        cmd_valid = 1'b0;
        wake = 1'b0;
      end
      flag_rd = rd_on && ($urandom_range(15) == 0);
      @(posedge clk);
      if (tick) n++;
      ticked = tick;
      if (flag_rd) begin exp_cold = 0; exp_off = 0; end
      @(negedge clk);
      if (n >= stop_n) post++;
    end
    tick = 0; cmd_valid = 0; wake = 0; flag_rd = 0;
  endtask

  task automatic start_cmd(input logic [1:0] c, input bit rd);
    cmd_valid = 1; cmd = c; tick = 0; wake = 0; flag_rd = rd;
    @(posedge clk);
    if (rd) begin exp_cold = 0; exp_off = 0; end
    if (c == 2'b01) exp_cold = 1; else exp_off = 1;
    n = 0; ticked = 0;
    @(negedge clk);
    cmd_valid = 0; flag_rd = 0;
  endtask

  task automatic wake_up();
    wake = 1; tick = 0; cmd_valid = 0; flag_rd = 0;
    @(posedge clk);
    n = T4; ticked = 0;
    @(negedge clk);
    wake = 0;
  endtask

  task automatic idle_noise(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      check_outputs(1'b1);
      cmd_valid = 1;
      cmd = ($urandom_range(1) == 0) ? 2'b00 : 2'b11;
      wake = $urandom_range(1);
      tick = $urandom_range(1);
      @(posedge clk);
      ticked = 0;
      @(negedge clk);
    end
    cmd_valid = 0; wake = 0; tick = 0;
  endtask

  task automatic check_reset_state();
    chk(slot_en == '1, "R10", "slot_en", int'(slot_en), 15);
    chk(sys_rst_n == 1'b1, "R10", "sys_rst_n", int'(sys_rst_n), 1);
    chk(regs_rst == 1'b0, "R10", "regs_rst", int'(regs_rst), 0);
    chk({cold_flag, off_flag} == 2'b00, "R10", "flags",
        int'({cold_flag, off_flag}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_reset_state();
    n = T5; ticked = 0;

    // R1 / R7: no-action, reserved codes and wake while idle
    idle_noise(40);

    // R2 R3 R4 R5 R6 R8: cold reset, steady ticks, stray commands
    start_cmd(2'b01, 1'b0);
    run_loop(1'b1, T5, 5, 100, 1'b1, 1'b0);
    chk(cold_flag == 1'b1, "R9", "cold_flag after regs_rst", int'(cold_flag), 1);
    flag_rd = 1;
    @(posedge clk); exp_cold = 0; exp_off = 0;
    @(negedge clk); flag_rd = 0;
    chk(cold_flag == 1'b0, "R9", "cold_flag after read", int'(cold_flag), 0);

    // R7 R8 R9: off flow started with a read in the same cycle
    start_cmd(2'b10, 1'b1);
    chk(off_flag == 1'b1, "R9", "set wins over read", int'(off_flag), 1);
    run_loop(1'b0, T4, 30, 50, 1'b1, 1'b1);
    wake_up();
    run_loop(1'b1, T5, 5, 60, 1'b1, 1'b1);

    // R2 R6: sparse ticks
    n = T5;
    start_cmd(2'b01, 1'b0);
    run_loop(1'b1, T5, 5, 30, 1'b1, 1'b1);

    // R10: power-on reset in the middle of an off flow
    start_cmd(2'b10, 1'b0);
    run_loop(1'b0, T2 + TS, 1, 80, 1'b0, 1'b0);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_reset_state();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule